// File: doc/BRIEF.md
# Status Register and Write Protection Unit

This unit keeps the eight-bit status byte of a serial non-volatile memory and decides whether each write may go ahead. A command decoder ahead of it sends one-cycle events: set the write latch, clear the write latch, write the status byte (with its data byte), and write to the array (with the target address). A write-protect pin, active low, takes part in the decision.

For every status-write or array-write event, the unit raises a permit flag in the same cycle when the write may proceed. A status write that is allowed takes effect at the next clock edge. The status byte is always available for read-back. Reset models power-up and clears every status bit. The backing store is not part of this unit.

Top module: `sr_guard`

## Requirements
- R1: While reset is asserted, and right after it is released, the status output reads 0x00.
- R2: A latch-set event sets status bit 1 at the next edge. A latch-clear event clears it. When both events arrive in the same cycle, the clear wins.
- R3: A status-write event while status bit 1 is 0 is refused: `sr_write_ok` stays 0 and the status byte does not change.
- R4: An accepted status write loads bits 7..2 and bit 0 from the data byte. Bit 1 keeps its previous value, whatever the data byte holds in bit 1.
- R5: When `wp_n` is 0 and status bit 7 is 1, every status write is refused. When `wp_n` is 1, a status write with bit 1 set is accepted whatever bit 7 holds.
- R6: An array-write event while status bit 1 is 0 is refused (`array_write_ok` stays 0).
- R7: Status bits 3:2 choose the protected range of addresses. 00 protects nothing. 01 protects addresses whose top two bits are 11. 10 protects addresses whose top bit is 1. 11 protects every address. An array write to a protected address is refused.
- R8: A refused array write changes nothing in the status byte. Bit 1 stays set until a latch-clear event or reset, and accepted writes do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, models power-up |
| wp_n | input | 1 | Write-protect pin, active low |
| ev_wren | input | 1 | Set write latch event |
| ev_wrdi | input | 1 | Clear write latch event |
| ev_wrsr | input | 1 | Status write event |
| wrsr_data | input | 8 | Data byte for the status write |
| ev_write | input | 1 | Array write event |
| write_addr | input | ADDR_W | Target address of the array write |
| status | output | 8 | Current status byte |
| sr_write_ok | output | 1 | Status write permitted this cycle |
| array_write_ok | output | 1 | Array write permitted this cycle |

## Verification
The bench builds the unit with the default 19-bit address. At that width, the addresses 0x3FFFF, 0x40000, 0x5FFFF, 0x60000 and 0x7FFFF sit exactly on the edges of the quarter, half and full protected ranges. The vector walk sets each protection code in turn and probes both sides of its edge. It also flips the pin while bit 7 is set, and sends status bytes whose bit 1 disagrees with the latch.

// File: rtl/sr_guard.sv
module sr_guard #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              ev_wren,
  input  logic              ev_wrdi,
  input  logic              ev_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              ev_write,
  input  logic [ADDR_W-1:0] write_addr,
  output logic [7:0]        status,
  output logic              sr_write_ok,
  output logic              array_write_ok
);
  localparam int TOP = ADDR_W - 1;

  logic [7:0] sr_q;
  logic       latch, lock, in_range;
  logic [1:0] bp;

  assign latch = sr_q[1];
  assign bp    = sr_q[3:2];
  assign lock  = sr_q[7] & ~wp_n;

  always_comb begin
    case (bp)
      2'b00:   in_range = 1'b0;
      2'b01:   in_range = &write_addr[TOP -: 2];
      2'b10:   in_range = write_addr[TOP];
      default: in_range = 1'b1;
    endcase
  end

  assign sr_write_ok    = ev_wrsr & latch & ~lock;
  assign array_write_ok = ev_write & latch & ~in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= 8'h00;
    end else begin
      if (sr_write_ok) begin
        sr_q[7:2] <= wrsr_data[7:2];
        sr_q[0]   <= wrsr_data[0];
      end
      if (ev_wrdi)      sr_q[1] <= 1'b0;
      else if (ev_wren) sr_q[1] <= 1'b1;
    end
  end

  assign status = sr_q;
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       ev_wren,
  input logic       ev_wrdi,
  input logic       ev_write,
  input logic [7:0] status,
  input logic       sr_write_ok,
  input logic       array_write_ok
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> status == 8'h00); // R1
  AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wren && !ev_wrdi) |=> status[1]); // R2
  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrdi |=> !status[1]); // R2
  AST_SR_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1] |-> !sr_write_ok); // R3
  AST_SR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_wren && !ev_wrdi && !sr_write_ok) |=> $stable(status)); // R3
  AST_SR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && status[7]) |-> !sr_write_ok); // R5
  AST_ARRAY_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1] |-> !array_write_ok); // R6
  AST_FULL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:2] == 2'b11) |-> !array_write_ok); // R7
  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !ev_wrdi) |=> status[1]); // R8
  AST_OK_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_write |-> !array_write_ok); // R8
endmodule

bind sr_guard sr_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .ev_wren(ev_wren), .ev_wrdi(ev_wrdi),
  .ev_write(ev_write), .status(status), .sr_write_ok(sr_write_ok),
  .array_write_ok(array_write_ok)
);

// File: tb/sr_guard_tb.sv
module sr_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  typedef struct packed {
    logic          wren;
    logic          wrdi;
    logic          wrsr;
    logic [7:0]    d;
    logic          wr;
    logic [AW-1:0] a;
    logic          wpn;
    logic          x_sr;
    logic          x_arr;
    logic [7:0]    x_st;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,8'hFF,1'b0,19'h00000,1'b1,1'b0,1'b0,8'h00,4'd3}, // R3
    '{1'b0,1'b0,1'b0,8'h00,1'b1,19'h00000,1'b1,1'b0,1'b0,8'h00,4'd6}, // R6
    '{1'b1,1'b0,1'b0,8'h00,1'b0,19'h00000,1'b1,1'b0,1'b0,8'h02,4'd2}, // R2
    '{1'b0,1'b0,1'b0,8'h00,1'b1,19'h7FFFF,1'b1,1'b0,1'b1,8'h02,4'd7}, // R7
    '{1'b0,1'b0,1'b1,8'h05,1'b0,19'h00000,1'b1,1'b1,1'b0,8'h07,4'd4}, // R4
    '{1'b0,1'b0,1'b0,8'h00,1'b1,19'h60000,1'b1,1'b0,1'b0,8'h07,4'd7}, // R7
    '{1'b0,1'b0,1'b0,8'h00,1'b1,19'h5FFFF,1'b1,1'b0,1'b1,8'h07,4'd7}, // R7
    '{1'b0,1'b0,1'b1,8'h88,1'b0,19'h00000,1'b1,1'b1,1'b0,8'h8A,4'd4}, // R4
    '{1'b0,1'b0,1'b0,8'h00,1'b1,19'h40000,1'b1,1'b0,1'b0,8'h8A,4'd8}, // R8
    '{1'b0,1'b0,1'b0,8'h00,1'b1,19'h3FFFF,1'b1,1'b0,1'b1,8'h8A,4'd7}, // R7
    '{1'b0,1'b0,1'b1,8'h0C,1'b0,19'h00000,1'b0,1'b0,1'b0,8'h8A,4'd5}, // R5
    '{1'b0,1'b0,1'b1,8'h0C,1'b0,19'h00000,1'b1,1'b1,1'b0,8'h0E,4'd5}, // R5
    '{1'b0,1'b0,1'b0,8'h00,1'b1,19'h00000,1'b1,1'b0,1'b0,8'h0E,4'd7}, // R7
    '{1'b0,1'b1,1'b0,8'h00,1'b0,19'h00000,1'b1,1'b0,1'b0,8'h0C,4'd2}, // R2
    '{1'b0,1'b0,1'b1,8'h00,1'b0,19'h00000,1'b1,1'b0,1'b0,8'h0C,4'd3}, // R3
    '{1'b1,1'b1,1'b0,8'h00,1'b0,19'h00000,1'b1,1'b0,1'b0,8'h0C,4'd2}, // R2
    '{1'b1,1'b0,1'b0,8'h00,1'b0,19'h00000,1'b1,1'b0,1'b0,8'h0E,4'd2}, // R2
    '{1'b0,1'b0,1'b1,8'hF1,1'b0,19'h00000,1'b1,1'b1,1'b0,8'hF3,4'd4}, // R4
    '{1'b0,1'b0,1'b0,8'h00,1'b1,19'h7FFFF,1'b0,1'b0,1'b1,8'hF3,4'd7}, // R7
    '{1'b0,1'b0,1'b1,8'h00,1'b0,19'h00000,1'b0,1'b0,1'b0,8'hF3,4'd5}, // R5
    '{1'b0,1'b0,1'b1,8'h00,1'b0,19'h00000,1'b1,1'b1,1'b0,8'h02,4'd4}  // R4
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_n = 1'b1;
  logic          ev_wren = 1'b0, ev_wrdi = 1'b0, ev_wrsr = 1'b0, ev_write = 1'b0;
  logic [7:0]    wrsr_data = 8'h00;
  logic [AW-1:0] write_addr = '0;
  logic [7:0]    status;
  logic          sr_write_ok, array_write_ok;
  int            errors = 0, checks = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_guard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .ev_wren(ev_wren), .ev_wrdi(ev_wrdi),
    .ev_wrsr(ev_wrsr), .wrsr_data(wrsr_data), .ev_write(ev_write),
    .write_addr(write_addr), .status(status), .sr_write_ok(sr_write_ok),
    .array_write_ok(array_write_ok)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ev_wren = 0; ev_wrdi = 0; ev_wrsr = 0; ev_write = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status in reset", status, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 status after release", status, 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ev_wren = VEC[i].wren; ev_wrdi = VEC[i].wrdi; ev_wrsr = VEC[i].wrsr;
      wrsr_data = VEC[i].d; ev_write = VEC[i].wr; write_addr = VEC[i].a;
      wp_n = VEC[i].wpn;
      #1;
      chk($sformatf("R%0d vec%0d sr_write_ok", VEC[i].req, i), {7'b0, sr_write_ok}, {7'b0, VEC[i].x_sr});
      chk($sformatf("R%0d vec%0d array_write_ok", VEC[i].req, i), {7'b0, array_write_ok}, {7'b0, VEC[i].x_arr});
      @(posedge clk); #1;
      idle();
      chk($sformatf("R%0d vec%0d status", VEC[i].req, i), status, VEC[i].x_st);
    end

    // R8: latch survives idle cycles
    repeat (4) @(posedge clk);
    #1;
    chk("R8 latch held while idle", status, 8'h02);

    // R1: reset mid-run clears latch
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears", status, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    ev_write = 1'b1; write_addr = '0;
    #1;
    chk("R6 write refused after reset", {7'b0, array_write_ok}, 8'h00);
    idle();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule